// File: doc/BRIEF.md
# SPI Host Controller with Register Interface

This block is an SPI master with a small 32-bit register bus. Software writes a word into the transmit register. The block then shifts that word out on the serial data output, most significant bit first. At the same time it shifts in an equal number of bits from the serial data input. When the word is complete, the received bits are latched into a receive register and a receive-ready flag is raised. The serial clock idles low. Data changes after a falling edge and is sampled on the rising edge. The serial clock runs at the system clock divided by the even parameter `CLK_DIV`.

A single holding register sits in front of the shift register. Software can therefore queue the next word while the current one is still shifting, and the two words go out back to back. The status word carries:

- ready flags for the holding register and for the receive register;
- a flag for the whole transmitter being idle;
- two sticky overrun flags, and their OR.

The control word has an interrupt-enable bit at the same position as each status bit it covers. It also has a force-select bit. While that bit is set, the active-low select line picked by the target-select mask is driven low, and it stays low across any number of words.

Top module: `spi_host_ctrl`

## Requirements
- R1: After reset, status reads 0x60 (transmitter-idle bit 5 and transmit-ready bit 6 set, all other bits zero), every select line is high, the serial clock is low and the interrupt output is low.
- R2: Registers are decoded from byte address bits 4:2: receive data at 0, transmit data at 4, status at 8, control at 12, target select at 20. Control reads back only bits 3, 4, 6, 7, 8 and 10, with all other bits reading zero. Target select reads back its low `NUM_SEL` bits.
- R3: A write to transmit data while transmit ready is set starts a word. The serial clock idles low, and output data is valid before the first rising edge. Bits leave most significant first and change only after a falling edge.
- R4: Each word produces exactly `WORD_W` rising serial-clock edges, spaced `CLK_DIV` system clocks apart.
- R5: Input data is sampled on each rising edge. When the word ends, the received bits appear zero-extended in receive data and receive ready (status bit 7) is set.
- R6: A read of receive data clears receive ready.
- R7: If a word completes while receive ready is still set, receive overrun (status bit 3) is set and receive data takes the new word. Error (status bit 8) is the OR of the two overrun flags.
- R8: A write to transmit data while transmit ready is low sets transmit overrun (status bit 4). The written word is discarded and never shifted.
- R9: Any write to status clears both overrun flags and the error bit and leaves the other status bits unchanged.
- R10: Transmit ready (bit 6) is high exactly when the holding register is free. Transmitter idle (bit 5) is high only when both the holding register and the shift register are idle. A queued second word is shifted immediately after the first.
- R11: While control bit 10 is set, each select line whose target-select mask bit is one is driven low. While bit 10 is clear, all select lines are high.
- R12: The interrupt output is the OR, over status bits 3, 4, 6, 7 and 8, of each status bit ANDed with the control bit at the same position.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address; bits 4:2 select the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the strobe |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NUM_SEL | Active-low target select lines |
| irq | output | 1 | Level interrupt |

## Verification
Read data is combinational, so a read returns the value held before the clock edge that ends that access. A read of receive data clears receive ready at that same edge. Register writes, and the status, select and interrupt changes they cause, become visible from the cycle after the write edge, and the bench samples them only once its bus task has returned past that edge. A word takes `WORD_W*CLK_DIV` system clocks plus a few more to load. Its completion time is therefore not counted by the bench. The bench polls status until the ready or idle flag appears, then checks the serial edge count and spacing that it recorded by timestamping the serial clock's rising edges.

// File: rtl/spi_host_pkg.sv
package spi_host_pkg;

   // register word index, taken from byte address bits 4:2
   localparam logic [2:0] W_RXD  = 3'd0;
   localparam logic [2:0] W_TXD  = 3'd1;
   localparam logic [2:0] W_STAT = 3'd2;
   localparam logic [2:0] W_CTRL = 3'd3;
   localparam logic [2:0] W_TSEL = 3'd5;

   // status bit positions, mirrored by enables in the control word
   localparam int unsigned B_ROE  = 3;
   localparam int unsigned B_TOE  = 4;
   localparam int unsigned B_TMT  = 5;
   localparam int unsigned B_TRDY = 6;
   localparam int unsigned B_RRDY = 7;
   localparam int unsigned B_ERR  = 8;
   localparam int unsigned B_FSEL = 10;

   localparam logic [31:0] IRQ_EN_MASK = (32'd1 << B_ROE) | (32'd1 << B_TOE) |
                                         (32'd1 << B_TRDY) | (32'd1 << B_RRDY) |
                                         (32'd1 << B_ERR);
   localparam logic [31:0] CTRL_MASK   = IRQ_EN_MASK | (32'd1 << B_FSEL);

   typedef struct packed {
      logic        sel;
      logic        wr;
      logic [2:0]  word;
      logic [31:0] data;
   } bus_req_t;

endpackage

// File: rtl/spi_host_baud.sv
module spi_host_baud #(
   parameter int unsigned HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);

   generate
      if (HALF == 1) begin : g_every
         assign tick = run;
      end else begin : g_count
         localparam int unsigned CW = $clog2(HALF);
         localparam logic [CW-1:0] TOP = CW'(HALF - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
            end else if (!run || cnt_q == TOP) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign tick = run && (cnt_q == TOP);
      end
   endgenerate

endmodule

// File: rtl/spi_host_shifter.sv
module spi_host_shifter #(
   parameter int unsigned WORD_W  = 8,
   parameter int unsigned CLK_DIV = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold_full,
   input  logic [WORD_W-1:0] hold_word,
   input  logic              miso,
   output logic              pop,
   output logic              busy,
   output logic              sclk,
   output logic              mosi,
   output logic              done,
   output logic [WORD_W-1:0] rx_word
);

   localparam int unsigned HALF  = CLK_DIV / 2;
   localparam int unsigned CNT_W = $clog2(WORD_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

   logic              tick;
   logic              busy_q;
   logic              sclk_q;
   logic [CNT_W-1:0]  bit_q;
   logic [WORD_W-1:0] tx_sh;
   logic [WORD_W-1:0] rx_sh;

   spi_host_baud #(.HALF(HALF)) u_baud (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy_q),
      .tick  (tick)
   );

   assign pop  = hold_full && !busy_q;
   assign done = busy_q && tick && sclk_q && (bit_q == LAST_BIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         sclk_q <= 1'b0;
         bit_q  <= '0;
         tx_sh  <= '0;
         rx_sh  <= '0;
      end else if (pop) begin
         tx_sh  <= hold_word;
         busy_q <= 1'b1;
         sclk_q <= 1'b0;
         bit_q  <= '0;
      end else if (busy_q && tick) begin
         if (!sclk_q) begin
            sclk_q <= 1'b1;
            rx_sh  <= {rx_sh[WORD_W-2:0], miso};
         end else begin
            sclk_q <= 1'b0;
            if (bit_q == LAST_BIT) begin
               busy_q <= 1'b0;
            end else begin
               bit_q <= bit_q + 1'b1;
               tx_sh <= {tx_sh[WORD_W-2:0], 1'b0};
            end
         end
      end
   end

   assign busy    = busy_q;
   assign sclk    = sclk_q;
   assign mosi    = tx_sh[WORD_W-1];
   assign rx_word = rx_sh;

   // R3
   sclk_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_q |-> !sclk_q);

   // R3
   load_starts_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pop |=> (busy_q && !sclk_q));

endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs
   import spi_host_pkg::*;
#(
   parameter int unsigned WORD_W  = 8,
   parameter int unsigned NUM_SEL = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  bus_req_t           req,
   output logic [31:0]        rdata,
   input  logic               xfer_busy,
   input  logic               xfer_pop,
   input  logic               xfer_done,
   input  logic [WORD_W-1:0]  xfer_rx,
   output logic               hold_full,
   output logic [WORD_W-1:0]  hold_word,
   output logic [NUM_SEL-1:0] sel_mask,
   output logic               force_sel,
   output logic               irq
);

   logic               tx_wr, st_wr, ct_wr, ts_wr, rx_rd;
   logic               full_q, rrdy_q, roe_q, toe_q;
   logic [WORD_W-1:0]  hold_q;
   logic [WORD_W-1:0]  rx_q;
   logic [31:0]        ctrl_q;
   logic [NUM_SEL-1:0] sel_q;
   logic [31:0]        stat_w;

   assign tx_wr = req.sel &&  req.wr && (req.word == W_TXD);
   assign st_wr = req.sel &&  req.wr && (req.word == W_STAT);
   assign ct_wr = req.sel &&  req.wr && (req.word == W_CTRL);
   assign ts_wr = req.sel &&  req.wr && (req.word == W_TSEL);
   assign rx_rd = req.sel && !req.wr && (req.word == W_RXD);

   // transmit holding register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         hold_q <= '0;
      end else if (tx_wr && !full_q) begin
         full_q <= 1'b1;
         hold_q <= req.data[WORD_W-1:0];
      end else if (xfer_pop) begin
         full_q <= 1'b0;
      end
   end

   // receive data and ready flag
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_q   <= '0;
         rrdy_q <= 1'b0;
      end else if (xfer_done) begin
         rx_q   <= xfer_rx;
         rrdy_q <= 1'b1;
      end else if (rx_rd) begin
         rrdy_q <= 1'b0;
      end
   end

   // sticky overrun flags: a new event wins over a clearing write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         roe_q <= 1'b0;
         toe_q <= 1'b0;
      end else begin
         if (xfer_done && rrdy_q && !rx_rd) begin
            roe_q <= 1'b1;
         end else if (st_wr) begin
            roe_q <= 1'b0;
         end
         if (tx_wr && full_q) begin
            toe_q <= 1'b1;
         end else if (st_wr) begin
            toe_q <= 1'b0;
         end
      end
   end

   // control and target select
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         sel_q  <= '0;
      end else begin
         if (ct_wr) begin
            ctrl_q <= req.data & CTRL_MASK;
         end
         if (ts_wr) begin
            sel_q <= req.data[NUM_SEL-1:0];
         end
      end
   end

   always_comb begin
      stat_w         = '0;
      stat_w[B_ROE]  = roe_q;
      stat_w[B_TOE]  = toe_q;
      stat_w[B_TMT]  = !full_q && !xfer_busy;
      stat_w[B_TRDY] = !full_q;
      stat_w[B_RRDY] = rrdy_q;
      stat_w[B_ERR]  = roe_q || toe_q;
   end

   always_comb begin
      rdata = '0;
      case (req.word)
         W_RXD:   rdata[WORD_W-1:0]  = rx_q;
         W_STAT:  rdata              = stat_w;
         W_CTRL:  rdata              = ctrl_q;
         W_TSEL:  rdata[NUM_SEL-1:0] = sel_q;
         default: rdata              = '0;
      endcase
   end

   assign hold_full = full_q;
   assign hold_word = hold_q;
   assign sel_mask  = sel_q;
   assign force_sel = ctrl_q[B_FSEL];
   assign irq       = |(stat_w & ctrl_q & IRQ_EN_MASK);

   // R5
   done_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done |=> rrdy_q);

   // R6
   read_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_rd && !xfer_done) |=> !rrdy_q);

   // R7
   rx_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done && rrdy_q && !rx_rd) |=> roe_q);

   // R8
   tx_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_wr && full_q) |=> (toe_q && $stable(hold_q)));

endmodule

// File: rtl/spi_host_ctrl.sv
module spi_host_ctrl
   import spi_host_pkg::*;
#(
   parameter int unsigned WORD_W  = 8,
   parameter int unsigned NUM_SEL = 4,
   parameter int unsigned CLK_DIV = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel,
   input  logic               bus_wr,
   input  logic [4:0]         bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   output logic               sclk,
   output logic               mosi,
   input  logic               miso,
   output logic [NUM_SEL-1:0] ss_n,
   output logic               irq
);

   generate
      if (WORD_W < 2 || WORD_W > 32) begin : g_bad_word
         initial $fatal(1, "spi_host_ctrl: WORD_W must lie in 2..32");
      end
      if (NUM_SEL < 1 || NUM_SEL > 32) begin : g_bad_sel
         initial $fatal(1, "spi_host_ctrl: NUM_SEL must lie in 1..32");
      end
      if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
         initial $fatal(1, "spi_host_ctrl: CLK_DIV must be even and at least 2");
      end
   endgenerate

   bus_req_t           req;
   logic               unused_addr_lsb;
   logic               pop, busy, done, hold_full, force_sel;
   logic [WORD_W-1:0]  hold_word, rx_word;
   logic [NUM_SEL-1:0] sel_mask;

   assign req             = '{sel: bus_sel, wr: bus_wr, word: bus_addr[4:2], data: bus_wdata};
   assign unused_addr_lsb = ^bus_addr[1:0];

   spi_host_regs #(.WORD_W(WORD_W), .NUM_SEL(NUM_SEL)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req),
      .rdata     (bus_rdata),
      .xfer_busy (busy),
      .xfer_pop  (pop),
      .xfer_done (done),
      .xfer_rx   (rx_word),
      .hold_full (hold_full),
      .hold_word (hold_word),
      .sel_mask  (sel_mask),
      .force_sel (force_sel),
      .irq       (irq)
   );

   spi_host_shifter #(.WORD_W(WORD_W), .CLK_DIV(CLK_DIV)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .hold_full (hold_full),
      .hold_word (hold_word),
      .miso      (miso),
      .pop       (pop),
      .busy      (busy),
      .sclk      (sclk),
      .mosi      (mosi),
      .done      (done),
      .rx_word   (rx_word)
   );

   for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
      assign ss_n[i] = !(force_sel && sel_mask[i]);
   end

endmodule

// File: tb/sim_spi_host_ctrl.sv
module sim_spi_host_ctrl;

   localparam int PERIOD  = 10;
   localparam int WORD_W  = 8;
   localparam int NUM_SEL = 4;
   localparam int CLK_DIV = 4;

   localparam logic [4:0] A_RX = 5'd0, A_TX = 5'd4, A_ST = 5'd8, A_CT = 5'd12, A_TS = 5'd20;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               bus_sel = 1'b0, bus_wr = 1'b0;
   logic [4:0]         bus_addr = '0;
   logic [31:0]        bus_wdata = '0;
   logic [31:0]        bus_rdata;
   logic               sclk, mosi, miso;
   logic [NUM_SEL-1:0] ss_n;
   logic               irq;

   int          n_vec = 0;
   int          n_bad = 0;
   bit          finished = 0;
   int          k = 0;
   int          rises = 0;
   longint      t_first = 0, t_last = 0;
   logic [63:0] stream = '0;
   logic [63:0] cap = '0;

   always #(PERIOD/2) clk = ~clk;

   spi_host_ctrl #(.WORD_W(WORD_W), .NUM_SEL(NUM_SEL), .CLK_DIV(CLK_DIV)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sclk(sclk), .mosi(mosi),
      .miso(miso), .ss_n(ss_n), .irq(irq)
   );

   // target model: presents bit k, advances after each falling edge
   assign miso = (k < 64) ? stream[63 - k] : 1'b0;
   always @(negedge sclk) k = k + 1;
   always @(posedge sclk) begin
      cap = {cap[62:0], mosi};
      if (rises == 0) t_first = $time;
      t_last = $time;
      rises = rises + 1;
   end

   task automatic check(input string tag, input longint act, input longint exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic arm(input logic [63:0] s);
      stream = s; k = 0; rises = 0; cap = '0;
   endtask

   task automatic wait_status(input int bitpos, input string tag);
      logic [31:0] st;
      bit seen = 0;
      for (int i = 0; i < 400 && !seen; i++) begin
         bus_read(A_ST, st);
         if (st[bitpos]) seen = 1;
      end
      check(tag, seen, 1);
   endtask

   task automatic test_reset();
      logic [31:0] st;
      bus_read(A_ST, st);
      check("R1 status", st, 32'h60);
      check("R1 ss_n", ss_n, {NUM_SEL{1'b1}});
      check("R1 sclk", sclk, 0);
      check("R1 irq", irq, 0);
   endtask

   task automatic test_map();
      logic [31:0] v;
      bus_write(A_CT, 32'hFFFF_FFFF);
      bus_read(A_CT, v);
      check("R2 ctrl readback", v, 32'h5D8);
      bus_write(A_CT, 32'h0);
      bus_write(A_TS, 32'hFFFF_FFFF);
      bus_read(A_TS, v);
      check("R2 tsel readback", v, (1 << NUM_SEL) - 1);
      bus_write(A_TS, 32'h0);
      bus_read(A_TS, v);
      check("R2 tsel cleared", v, 0);
   endtask

   task automatic test_single(input logic [7:0] tx, input logic [7:0] rx);
      logic [31:0] v;
      arm({rx, 56'h0});
      bus_write(A_TX, {24'hABCDEF, tx});
      bus_read(A_ST, v);
      check("R10 not idle while shifting", v[5], 0);
      wait_status(7, "R5 ready raised");
      check("R3 msb first", cap[7:0], tx);
      check("R4 edge count", rises, WORD_W);
      check("R4 edge spacing", t_last - t_first, (WORD_W - 1) * CLK_DIV * PERIOD);
      check("R3 sclk idle", sclk, 0);
      bus_read(A_ST, v);
      check("R10 idle after word", v[6:5], 2'b11);
      bus_read(A_RX, v);
      check("R5 rx data", v, {24'h0, rx});
      bus_read(A_ST, v);
      check("R6 ready cleared", v, 32'h60);
   endtask

   task automatic test_overrun();
      logic [31:0] v;
      arm({8'h96, 8'h3B, 48'h0});
      bus_write(A_TX, 32'hC3);
      bus_write(A_TX, 32'h5E);
      bus_read(A_ST, v);
      check("R10 holding full", v[6:5], 2'b00);
      bus_write(A_TX, 32'hFF);
      bus_read(A_ST, v);
      check("R8 tx overrun and error", {v[8], v[4]}, 2'b11);
      wait_status(5, "R10 idle after queue");
      check("R10 back-to-back bits", cap[15:0], 16'hC35E);
      check("R8 dropped word not shifted", rises, 2 * WORD_W);
      bus_read(A_ST, v);
      check("R7 rx overrun", v, 32'h1F8);
      bus_write(A_ST, 32'h0);
      bus_read(A_ST, v);
      check("R9 sticky cleared", v, 32'hE0);
      bus_read(A_RX, v);
      check("R7 newest word kept", v, 32'h3B);
      bus_read(A_ST, v);
      check("R6 ready cleared", v, 32'h60);
   endtask

   task automatic test_select();
      logic [31:0] v;
      bus_write(A_TS, 32'h4);
      check("R11 no force", ss_n, 4'hF);
      bus_write(A_CT, 32'h400);
      check("R11 forced", ss_n, 4'hB);
      arm({8'h11, 56'h0});
      bus_write(A_TX, 32'h22);
      wait_status(5, "R11 word done");
      check("R11 held across word", ss_n, 4'hB);
      bus_read(A_RX, v);
      bus_write(A_CT, 32'h0);
      check("R11 released", ss_n, 4'hF);
      bus_write(A_TS, 32'h0);
   endtask

   task automatic test_irq();
      logic [31:0] v;
      bus_write(A_CT, 32'h80);
      check("R12 idle no irq", irq, 0);
      arm({8'h5A, 56'h0});
      bus_write(A_TX, 32'h33);
      wait_status(7, "R12 word done");
      check("R12 ready irq", irq, 1);
      bus_read(A_RX, v);
      check("R12 irq drops", irq, 0);
      bus_write(A_CT, 32'h40);
      check("R12 tx ready irq", irq, 1);
      bus_write(A_CT, 32'h0);
      check("R12 disabled", irq, 0);
   endtask

   task automatic summary();
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      #(PERIOD * 150000);
      if (!finished) begin
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      test_reset();
      test_map();
      test_single(8'hA5, 8'h3C);
      test_single(8'h01, 8'h80);
      test_overrun();
      test_select();
      test_irq();
      summary();
   end

endmodule